// File: doc/BRIEF.md
# I2C Register-Port Target with Pointer Auto-Increment

This block is a two-wire serial target that gives a host controller access to a bank of 8-bit control registers. It oversamples the clock and data lines against a faster system clock, finds start and stop conditions, and checks a 7-bit device address. The lowest address bit comes from a board strap input. After a write address, the first byte loads a register pointer. Its top bit selects whether the pointer steps forward after every data byte. The data bytes that follow are written to the register file through a one-cycle write strobe.

A read transaction cannot load the pointer. The host first sends a write that carries only the pointer byte and ends it with a stop. It then opens a read, which returns register contents starting at that pointer. Each returned byte is acknowledged by the host, and a not-acknowledge ends the read. The target only pulls the data line low through an output enable, and never drives it high. The register storage is outside the block. The block presents a pointer address, a write strobe and write data, and takes combinational read data back.

Top module: `regport_i2c_target`

## Requirements
- R1: The target answers only the address byte whose upper seven bits equal 1001,01 followed by the strap level, and whose bit 0 is the direction (0 write, 1 read). On a match it pulls SDA low in the ninth clock. On a mismatch it never drives SDA, and it neither writes nor returns data until the next start.
- R2: The first byte after a write address is the pointer byte and is acknowledged. Bit 7 is the step-enable flag and bits 6..0 are the register pointer.
- R3: Each complete data byte received after the pointer byte produces exactly one single-cycle write strobe. The strobe carries that byte and the current pointer as address, and each data byte is acknowledged.
- R4: With the step flag set, every data byte transferred in either direction advances the pointer by one, and the pointer wraps from 127 to 0.
- R5: With the step flag clear, the pointer stays fixed, so repeated writes or reads hit the same register.
- R6: A read returns, MSB first, the register selected by the pointer from the last pointer byte, and the read leaves that pointer unchanged except for stepping.
- R7: A write stopped right after the acknowledged pointer byte writes no register, and it keeps the new pointer visible on the address port.
- R8: After the host answers a read byte with a not-acknowledge, the target releases SDA and sends no further data bits until a new start.
- R9: A start seen at any point, including in the middle of a byte without a preceding stop, restarts address reception.
- R10: The target changes its SDA enable only while SCL is low.
- R11: After reset, SDA is released, no write strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| addr_strap_i | input | 1 | Level supplying the lowest device-address bit |
| rf_addr_o | output | 7 | Register pointer, used as read and write address |
| rf_wdata_o | output | 8 | Write data for the register file |
| rf_we_o | output | 1 | One-cycle register write strobe |
| rf_rdata_i | input | 8 | Register contents at rf_addr_o, combinational |

## Verification
The assertions assume that SCL and SDA are held for many system clocks between changes. They also assume that the host moves SDA only while SCL is low, except to form start and stop conditions, and that the strap stays constant during a transaction. The bench host drives each bus phase for sixteen system clocks, and it changes its data only after it has pulled SCL low. It sets the strap only while the bus is idle. The stop conditions in the stimulus come only after the target has let go of SDA, so a release forced by a stop never falls on a high SCL.

// File: rtl/regport_i2c_pkg.sv
package regport_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MAP,
        ST_MAP_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    assign scl_o      = synced[0];
    assign sda_o      = synced[1];
    assign scl_rise_o = synced[0] & ~prev_q[0];
    assign scl_fall_o = ~synced[0] & prev_q[0];
    assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
    assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import regport_i2c_pkg::*;
#(
    parameter int          PTR_W      = 7,
    parameter int          DATA_W     = 8,
    parameter int          PREFIX_W   = 6,
    parameter logic [PREFIX_W-1:0] DEV_PREFIX = 6'b100101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sda_oe_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              we_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] txb;
        logic [PTR_W-1:0]  ptr;
        logic              incr;
        logic              rw;
        logic              nack;
        logic              oe;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } fsm_t;

    fsm_t q, d;
    logic addr_match;

    assign addr_match = (q.sh[DATA_W-1:1] == {DEV_PREFIX, strap_i});

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_MAP, ST_WDATA: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[DATA_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                        if (q.st == ST_WDATA && q.cnt == LAST_BIT) begin
                            d.we    = 1'b1;
                            d.wdata = {q.sh[DATA_W-2:0], sda_lvl};
                        end
                    end else if (scl_fall && q.cnt == FULL) begin
                        case (q.st)
                            ST_ADDR: begin
                                if (addr_match) begin
                                    d.st = ST_ADDR_ACK;
                                    d.oe = 1'b1;
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            ST_MAP: begin
                                d.ptr  = q.sh[PTR_W-1:0];
                                d.incr = q.sh[DATA_W-1];
                                d.st   = ST_MAP_ACK;
                                d.oe   = 1'b1;
                            end
                            default: begin
                                if (q.incr) d.ptr = q.ptr + 1'b1;
                                d.st = ST_WDATA_ACK;
                                d.oe = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st  = ST_RDATA;
                            d.txb = rdata_i;
                            d.oe  = ~rdata_i[DATA_W-1];
                        end else begin
                            d.st = ST_MAP;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_MAP_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WDATA;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st = ST_RACK;
                            d.oe = 1'b0;
                            if (q.incr) d.ptr = q.ptr + 1'b1;
                        end else begin
                            d.txb = {q.txb[DATA_W-2:0], 1'b0};
                            d.oe  = ~q.txb[DATA_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st  = ST_RDATA;
                            d.txb = rdata_i;
                            d.oe  = ~rdata_i[DATA_W-1];
                            d.cnt = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, txb: '0, ptr: '0,
                   incr: 1'b0, rw: 1'b0, nack: 1'b0, oe: 1'b0,
                   we: 1'b0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign ptr_o    = q.ptr;
    assign wdata_o  = q.wdata;
    assign we_o     = q.we;

    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR_ACK) |-> (q.sh[DATA_W-1:1] == {DEV_PREFIX, strap_i})); // R1
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we); // R3
    AST_WE_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> (q.st == ST_WDATA)); // R7
    AST_PTR_MOVES_ONLY_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ptr != $past(q.ptr)) |-> ($past(q.st) == ST_MAP || $past(q.incr))); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe); // R8
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_lvl); // R10

endmodule

// File: rtl/regport_i2c_target.sv
module regport_i2c_target #(
    parameter int SYNC_STAGES = 2,
    parameter int PTR_W       = 7,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              addr_strap_i,
    output logic [PTR_W-1:0]  rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              rf_we_o,
    input  logic [DATA_W-1:0] rf_rdata_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_fsm #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (addr_strap_i),
        .rdata_i   (rf_rdata_i),
        .sda_oe_o  (sda_oe_o),
        .ptr_o     (rf_addr_o),
        .wdata_o   (rf_wdata_o),
        .we_o      (rf_we_o)
    );

endmodule

// File: tb/regport_i2c_target_tb.sv
module regport_i2c_target_tb;
    localparam int PH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic strap = 1'b1;
    logic sda_oe, rf_we;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic sda_line;
    logic [7:0] regs [128];
    int tests = 0, fails = 0, we_cnt = 0, viol = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;
    assign rf_rdata = regs[rf_addr];

    regport_i2c_target u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (host_scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .addr_strap_i (strap),
        .rf_addr_o    (rf_addr),
        .rf_wdata_o   (rf_wdata),
        .rf_we_o      (rf_we),
        .rf_rdata_i   (rf_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
        end else if (rf_we) begin
            regs[rf_addr] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
        oe_prev <= sda_oe;
        if (rst_n && sda_oe != oe_prev && host_scl) viol <= viol + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ph(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        host_sda = 1'b1; wait_ph(PH);
        host_scl = 1'b1; wait_ph(PH);
        host_sda = 1'b0; wait_ph(PH);
        host_scl = 1'b0; wait_ph(PH);
    endtask

    task automatic bus_stop;
        host_sda = 1'b0; wait_ph(PH);
        host_scl = 1'b1; wait_ph(PH);
        host_sda = 1'b1; wait_ph(PH);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    wait_ph(PH);
        host_scl = 1'b1; wait_ph(PH);
        host_scl = 1'b0; wait_ph(PH);
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; wait_ph(PH);
        host_scl = 1'b1; wait_ph(PH / 2);
        b = sda_line;    wait_ph(PH / 2);
        host_scl = 1'b0; wait_ph(PH);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] dev_byte(input logic ad, input logic rd);
        return {6'b100101, ad, rd};
    endfunction

    task automatic set_pointer(input logic [7:0] map);
        logic a;
        bus_start;
        write_byte(dev_byte(strap, 1'b0), a);
        check(a, "R1 address ack", a, 1);
        write_byte(map, a);
        check(a, "R2 pointer byte ack", a, 1);
    endtask

    task automatic t_reset;
        check(sda_oe == 1'b0, "R11 oe after reset", sda_oe, 0);
        check(rf_we == 1'b0, "R11 we after reset", rf_we, 0);
        check(rf_addr == 7'd0, "R11 ptr after reset", rf_addr, 0);
    endtask

    task automatic t_write_step;
        logic a;
        int c0 = we_cnt;
        set_pointer(8'h90);
        write_byte(8'hA1, a); check(a, "R3 data ack", a, 1);
        write_byte(8'hB2, a);
        write_byte(8'hC3, a);
        bus_stop;
        check(regs[16] == 8'hA1, "R3 first byte", regs[16], 8'hA1);
        check(regs[17] == 8'hB2, "R4 step second", regs[17], 8'hB2);
        check(regs[18] == 8'hC3, "R4 step third", regs[18], 8'hC3);
        check(we_cnt - c0 == 3, "R3 strobe count", we_cnt - c0, 3);
        check(rf_addr == 7'd19, "R4 pointer after write", rf_addr, 19);
    endtask

    task automatic t_write_fixed;
        logic a;
        int c0 = we_cnt;
        set_pointer(8'h05);
        write_byte(8'h11, a);
        write_byte(8'h22, a);
        bus_stop;
        check(regs[5] == 8'h22, "R5 fixed reg", regs[5], 8'h22);
        check(regs[6] == 8'h00, "R5 neighbour untouched", regs[6], 0);
        check(we_cnt - c0 == 2, "R3 strobe count fixed", we_cnt - c0, 2);
        check(rf_addr == 7'd5, "R5 pointer held", rf_addr, 5);
    endtask

    task automatic t_wrap;
        logic a;
        set_pointer(8'hFF);
        write_byte(8'h5A, a);
        write_byte(8'h6B, a);
        bus_stop;
        check(regs[127] == 8'h5A, "R4 last reg", regs[127], 8'h5A);
        check(regs[0] == 8'h6B, "R4 wrap to 0", regs[0], 8'h6B);
    endtask

    task automatic t_preamble_read;
        logic a;
        logic [7:0] v;
        int c0 = we_cnt;
        set_pointer(8'h90);
        bus_stop;
        check(we_cnt == c0, "R7 no write on abort", we_cnt - c0, 0);
        check(rf_addr == 7'd16, "R7 pointer kept", rf_addr, 16);
        bus_start;
        write_byte(dev_byte(strap, 1'b1), a);
        check(a, "R1 read address ack", a, 1);
        read_byte(v, 1'b1); check(v == 8'hA1, "R6 read first", v, 8'hA1);
        read_byte(v, 1'b1); check(v == 8'hB2, "R4 read step", v, 8'hB2);
        read_byte(v, 1'b0); check(v == 8'hC3, "R4 read step last", v, 8'hC3);
        read_byte(v, 1'b0);
        check(v == 8'hFF, "R8 no data after nack", v, 8'hFF);
        bus_stop;
        check(rf_addr == 7'd19, "R6 pointer only stepped", rf_addr, 19);
    endtask

    task automatic t_read_fixed;
        logic a;
        logic [7:0] v;
        set_pointer(8'h05);
        bus_stop;
        bus_start;
        write_byte(dev_byte(strap, 1'b1), a);
        read_byte(v, 1'b1); check(v == 8'h22, "R5 read fixed 1", v, 8'h22);
        read_byte(v, 1'b0); check(v == 8'h22, "R5 read fixed 2", v, 8'h22);
        bus_stop;
    endtask

    task automatic t_wrong_addr;
        logic a;
        int c0 = we_cnt;
        bus_start;
        write_byte(dev_byte(~strap, 1'b0), a);
        check(!a, "R1 mismatch not acked", a, 0);
        write_byte(8'h40, a);
        write_byte(8'hEE, a);
        check(!a, "R1 mismatch no ack on data", a, 0);
        bus_stop;
        check(we_cnt == c0, "R1 mismatch no write", we_cnt - c0, 0);
        check(regs[64] == 8'h00, "R1 mismatch reg untouched", regs[64], 0);
    endtask

    task automatic t_restart;
        logic a;
        logic [7:0] v;
        set_pointer(8'h20);
        write_byte(8'h77, a);
        bus_start;
        write_byte(dev_byte(strap, 1'b1), a);
        check(a, "R9 repeated start read ack", a, 1);
        read_byte(v, 1'b0);
        check(v == 8'h77, "R9 read after repeated start", v, 8'h77);
        bus_stop;
        bus_start;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        set_pointer(8'h30);
        write_byte(8'h3C, a);
        bus_stop;
        check(regs[48] == 8'h3C, "R9 mid-byte restart write", regs[48], 8'h3C);
    endtask

    task automatic t_strap_low;
        logic a;
        strap = 1'b0;
        wait_ph(PH);
        set_pointer(8'h41);
        write_byte(8'h9D, a);
        bus_stop;
        check(regs[65] == 8'h9D, "R1 strap low match", regs[65], 8'h9D);
        strap = 1'b1;
        wait_ph(PH);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_ph(5);
        rst_n = 1'b1;
        wait_ph(5);
        t_reset;
        t_write_step;
        t_write_fixed;
        t_wrap;
        t_preamble_read;
        t_read_fixed;
        t_wrong_addr;
        t_restart;
        t_strap_low;
        check(viol == 0, "R10 sda enable moved with scl high", viol, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule